// File: doc/BRIEF.md
# Time-Base Interval Timer

This block is a free-running prescaler that counts at half the oscillator rate and produces a periodic interval event. A two-bit select in a small control word picks one of four counter stages. When the chosen stage carries out, a sticky interval flag is set. An interrupt request is raised while that flag and an enable bit are both 1. The count value is exported so that a watchdog and an oscillator-settling timer elsewhere in the clock section can take their own taps from it.

The counter returns to zero from four sources:
- a synchronous reset;
- a write of 0 to a self-restoring clear bit in the control word;
- the rising edge of a stop-mode request;
- a change of the machine clock from the oscillator to the PLL, seen as the clock-select input falling from 1 to 0.

Software clears the flag by writing 0 to it. An overflow that lands in the same cycle as that write wins, and the flag stays set.

Top module: `interval_tick_timer`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, the count is 0. The control word then reads 5'b10000 and `irq_o` is 0.
- R2: After a clear, the count reads floor(n/2) modulo 2^CNT_W after the n-th rising clock edge, so it advances once every two oscillator cycles.
- R3: A write with control bit 4 equal to 0 makes the count 0 after that edge. A write with bit 4 equal to 1 leaves the count running, and bit 4 always reads 1.
- R4: A rising edge on `stop_req` makes the count 0 after the edge where it is first seen high. Holding `stop_req` high does not clear the count again.
- R5: A fall of `clk_sel_osc` from 1 to 0 makes the count 0 after that edge. A rise of `clk_sel_osc` does not clear the count.
- R6: Control bits 3:2 select the interval, with values 0, 1, 2 and 3 giving periods P of 2^(TAP0+2), 2^(TAP1+2), 2^(TAP2+2) and 2^(TAP3+2) oscillator cycles. With the default parameters these are 2^12, 2^14, 2^16 and 2^19. The interval flag sets at edge k·P+1 counted from the last clear, for k ≥ 1, and never earlier.
- R7: The interval flag (control bit 0) is sticky. Writing 0 to it clears it, and writing 1 to it leaves it unchanged.
- R8: If an overflow and a write of 0 to the flag fall on the same edge, the flag ends set.
- R9: `irq_o` is 1 exactly when the flag (bit 0) and the enable (bit 1) are both 1.
- R10: The control word layout is: bit 0 interval flag, bit 1 interrupt enable, bits 3:2 interval select, bit 4 counter clear. Enable and select take the written value on the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word write data |
| ctl_rdata | output | 5 | Control word read data |
| stop_req | input | 1 | Stop-mode request level; its rising edge clears the count |
| clk_sel_osc | input | 1 | 1 = machine clock from oscillator, 0 = from PLL |
| irq_o | output | 1 | Interval interrupt request |
| cnt_o | output | CNT_W | Prescaler count for watchdog and settling-timer taps |

## Verification
Each clear source and each control write takes effect on the edge where it is sampled. The count and the register fields are therefore due in the cycle right after that edge. The interval flag is due one edge later than the carry that sets it, at edge k·P+1 from the last clear, and `irq_o` follows the flag and enable with no added delay.

A behavioural model in the bench advances on every rising edge using only edge counts since the last clear. All outputs are compared 2 ns after each falling edge, so every value read has settled from the edge before. Directed checks count edges from a known clear to confirm the flag stays 0 through edge P and is 1 at edge P+1. They also place a flag-clear write exactly on an overflow edge.

// File: rtl/tbt_pkg.sv
`timescale 1ns/1ps
package tbt_pkg;

    // Interval select codes; each picks one counter stage.
    typedef enum logic [1:0] {
        IVL_STAGE0 = 2'd0,
        IVL_STAGE1 = 2'd1,
        IVL_STAGE2 = 2'd2,
        IVL_STAGE3 = 2'd3
    } ivl_sel_e;

    // Control word, MSB first: clear bit, select, enable, flag.
    typedef struct packed {
        logic     cnt_keep;
        ivl_sel_e sel;
        logic     irq_en;
        logic     ivl_flag;
    } ctl_word_t;

    localparam int CTL_W = $bits(ctl_word_t);

    // Independent reasons to zero the prescaler.
    typedef struct packed {
        logic sw_clr;
        logic stop_entry;
        logic pll_switch;
    } clr_src_t;

    function automatic logic any_clear(input clr_src_t s);
        return |s;
    endfunction

    function automatic logic rose(input logic prev, input logic now);
        return now & ~prev;
    endfunction

    function automatic logic fell(input logic prev, input logic now);
        return prev & ~now;
    endfunction

endpackage

// File: rtl/tbt_clear_ctl.sv
`timescale 1ns/1ps
module tbt_clear_ctl
    import tbt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sw_clr_i,
    input  logic stop_req_i,
    input  logic clk_sel_osc_i,
    output logic clr_o
);

    logic     stop_q;
    logic     osc_q;
    clr_src_t src;

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q <= 1'b0;
            osc_q  <= 1'b0;
        end else begin
            stop_q <= stop_req_i;
            osc_q  <= clk_sel_osc_i;
        end
    end

    always_comb begin
        src.sw_clr     = sw_clr_i;
        src.stop_entry = rose(stop_q, stop_req_i);
        src.pll_switch = fell(osc_q, clk_sel_osc_i);
        clr_o          = any_clear(src);
    end

    // R4
    stop_entry_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_req_i) |-> clr_o);

    // R5
    pll_switch_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_sel_osc_i) |-> clr_o);

endmodule

// File: rtl/tbt_prescaler.sv
`timescale 1ns/1ps
module tbt_prescaler #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             half_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             half_q;

    // half_q divides the oscillator by two; the counter steps when it is 1.
    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q  <= '0;
            half_q <= 1'b0;
        end else begin
            half_q <= ~half_q;
            if (half_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign half_o = half_q;

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_q == '0) && !half_q);

    // R2
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && half_q) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

endmodule

// File: rtl/tbt_tap_select.sv
`timescale 1ns/1ps
module tbt_tap_select
    import tbt_pkg::*;
#(
    parameter int CNT_W = 18,
    parameter int TAP0  = 10,
    parameter int TAP1  = 12,
    parameter int TAP2  = 14,
    parameter int TAP3  = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             half_i,
    input  logic             clr_i,
    input  ivl_sel_e         sel_i,
    output logic             ovf_o
);

    localparam int NTAP = 4;

    logic [NTAP-1:0] full;
    logic            ovf_q;

    // A stage carries when it and every bit below it are 1 on a step cycle.
    for (genvar i = 0; i < NTAP; i++) begin : g_tap
        localparam int TP = (i == 0) ? TAP0 : (i == 1) ? TAP1 : (i == 2) ? TAP2 : TAP3;
        assign full[i] = &cnt_i[TP:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= half_i && !clr_i && full[sel_i];
        end
    end

    assign ovf_o = ovf_q;

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> !ovf_q);

endmodule

// File: rtl/tbt_ctl_reg.sv
`timescale 1ns/1ps
module tbt_ctl_reg
    import tbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [CTL_W-1:0] wdata_i,
    input  logic             ovf_i,
    output ctl_word_t        ctl_o,
    output logic             sw_clr_o
);

    ctl_word_t wr_w;
    logic      flag_q;
    logic      ie_q;
    ivl_sel_e  sel_q;

    assign wr_w = ctl_word_t'(wdata_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            ie_q   <= 1'b0;
            sel_q  <= IVL_STAGE0;
        end else begin
            if (we_i) begin
                ie_q  <= wr_w.irq_en;
                sel_q <= wr_w.sel;
            end
            if (ovf_i) begin
                flag_q <= 1'b1;
            end else if (we_i && !wr_w.ivl_flag) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign ctl_o    = '{cnt_keep: 1'b1, sel: sel_q, irq_en: ie_q, ivl_flag: flag_q};
    assign sw_clr_o = we_i && !wr_w.cnt_keep;

    // R8
    ovf_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_i |=> flag_q);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (we_i && !wr_w.ivl_flag && !ovf_i) |=> !flag_q);

    // R7
    flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (we_i && wr_w.ivl_flag && !ovf_i) |=> $stable(flag_q));

endmodule

// File: rtl/interval_tick_timer.sv
`timescale 1ns/1ps
module interval_tick_timer
    import tbt_pkg::*;
#(
    parameter int CNT_W = 18,
    parameter int TAP0  = 10,
    parameter int TAP1  = 12,
    parameter int TAP2  = 14,
    parameter int TAP3  = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [4:0]       ctl_wdata,
    output logic [4:0]       ctl_rdata,
    input  logic             stop_req,
    input  logic             clk_sel_osc,
    output logic             irq_o,
    output logic [CNT_W-1:0] cnt_o
);

    logic             sw_clr;
    logic             clr;
    logic             half;
    logic             ovf;
    logic [CNT_W-1:0] cnt;
    ctl_word_t        ctl;

    tbt_ctl_reg u_ctl (
        .clk      (clk),
        .rst      (rst),
        .we_i     (ctl_we),
        .wdata_i  (ctl_wdata),
        .ovf_i    (ovf),
        .ctl_o    (ctl),
        .sw_clr_o (sw_clr)
    );

    tbt_clear_ctl u_clr (
        .clk           (clk),
        .rst           (rst),
        .sw_clr_i      (sw_clr),
        .stop_req_i    (stop_req),
        .clk_sel_osc_i (clk_sel_osc),
        .clr_o         (clr)
    );

    tbt_prescaler #(.CNT_W(CNT_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr),
        .cnt_o  (cnt),
        .half_o (half)
    );

    tbt_tap_select #(
        .CNT_W (CNT_W),
        .TAP0  (TAP0),
        .TAP1  (TAP1),
        .TAP2  (TAP2),
        .TAP3  (TAP3)
    ) u_tap (
        .clk    (clk),
        .rst    (rst),
        .cnt_i  (cnt),
        .half_i (half),
        .clr_i  (clr),
        .sel_i  (ctl.sel),
        .ovf_o  (ovf)
    );

    assign ctl_rdata = ctl;
    assign irq_o     = ctl.ivl_flag & ctl.irq_en;
    assign cnt_o     = cnt;

endmodule

// File: tb/tb_interval_tick_timer.sv
`timescale 1ns/1ps
module tb_interval_tick_timer;

    localparam int CW = 8;
    localparam int T0 = 1;
    localparam int T1 = 3;
    localparam int T2 = 5;
    localparam int T3 = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          we = 1'b0;
    logic [4:0]    wd = '0;
    logic [4:0]    rd;
    logic          stop = 1'b0;
    logic          csel = 1'b1;
    logic          irq;
    logic [CW-1:0] cnt;

    always #4 clk = ~clk;

    interval_tick_timer #(.CNT_W(CW), .TAP0(T0), .TAP1(T1), .TAP2(T2), .TAP3(T3)) dut (
        .clk (clk), .rst (rst), .ctl_we (we), .ctl_wdata (wd), .ctl_rdata (rd),
        .stop_req (stop), .clk_sel_osc (csel), .irq_o (irq), .cnt_o (cnt)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Reference model state: edges since last clear plus register fields.
    int         n_m;
    logic       flag_m, ie_m, pend_m, stop_pm, csel_pm, clr_m, newp_m;
    logic [1:0] sel_m;

    function automatic int period(input logic [1:0] s);
        case (s)
            2'd0:    return 1 << (T0 + 2);
            2'd1:    return 1 << (T1 + 2);
            2'd2:    return 1 << (T2 + 2);
            default: return 1 << (T3 + 2);
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            n_m = 0; flag_m = 0; ie_m = 0; sel_m = 0; pend_m = 0; stop_pm = 0; csel_pm = 0;
        end else begin
            clr_m  = (we && !wd[4]) || (stop && !stop_pm) || (!csel && csel_pm);
            newp_m = !clr_m && (((n_m + 1) % period(sel_m)) == 0);
            if (pend_m) flag_m = 1'b1;
            else if (we && !wd[0]) flag_m = 1'b0;
            if (we) begin
                ie_m  = wd[1];
                sel_m = wd[3:2];
            end
            pend_m  = newp_m;
            n_m     = clr_m ? 0 : n_m + 1;
            stop_pm = stop;
            csel_pm = csel;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            chk(cnt == CW'((n_m / 2) % (1 << CW)), "R2 R3 R4 R5 count", int'(cnt), (n_m / 2) % (1 << CW));
            chk(rd == {1'b1, sel_m, ie_m, flag_m}, "R6 R7 R8 R10 control word", int'(rd),
                int'({1'b1, sel_m, ie_m, flag_m}));
            chk(irq == (flag_m & ie_m), "R9 irq", int'(irq), int'(flag_m & ie_m));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [4:0] d);
        we = 1'b1;
        wd = d;
        @(negedge clk);
        we = 1'b0;
        wd = '0;
    endtask

    // Two clearing writes: the second edge clears the flag with no overflow pending.
    task automatic restart(input logic [1:0] s, input logic e);
        wr({1'b0, s, e, 1'b0});
        wr({1'b0, s, e, 1'b0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        chk(cnt == '0, "R1 count after reset", int'(cnt), 0);
        chk(rd == 5'b10000, "R1 control word after reset", int'(rd), 16);
        chk(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
        @(negedge clk);

        // R6: flag timing for every select code.
        for (int s = 0; s < 4; s++) begin
            int p;
            p = period(2'(s));
            restart(2'(s), 1'b1);
            for (int k = 1; k <= p; k++) begin
                @(negedge clk);
                #2;
                if (k == p) chk(rd[0] == 1'b0, "R6 flag still clear at edge P", int'(rd[0]), 0);
            end
            @(negedge clk);
            #2;
            chk(rd[0] == 1'b1, "R6 flag set at edge P+1", int'(rd[0]), 1);
            chk(irq == 1'b1, "R9 irq with flag and enable", int'(irq), 1);
        end

        // R7: write one keeps flag, write zero clears it (select 3, long period).
        wr(5'b11111);
        #2;
        chk(rd[0] == 1'b1, "R7 write one keeps flag", int'(rd[0]), 1);
        chk(cnt != '0, "R3 write one to clear bit keeps count", int'(cnt), 1);
        @(negedge clk);
        wr(5'b11110);
        #2;
        chk(rd[0] == 1'b0, "R7 write zero clears flag", int'(rd[0]), 0);
        chk(irq == 1'b0, "R9 irq drops with flag", int'(irq), 0);
        @(negedge clk);

        // R3: software clear.
        repeat (9) @(negedge clk);
        wr(5'b01110);
        #2;
        chk(cnt == '0, "R3 software clear", int'(cnt), 0);
        @(negedge clk);

        // R4: stop entry clears once.
        repeat (11) @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        #2;
        chk(cnt == '0, "R4 stop entry clears", int'(cnt), 0);
        repeat (6) @(negedge clk);
        #2;
        chk(cnt == CW'(3), "R4 held stop does not clear again", int'(cnt), 3);
        @(negedge clk);
        stop = 1'b0;

        // R5: oscillator-to-PLL switch clears, reverse does not.
        repeat (13) @(negedge clk);
        csel = 1'b0;
        @(negedge clk);
        #2;
        chk(cnt == '0, "R5 clock switch clears", int'(cnt), 0);
        repeat (8) @(negedge clk);
        csel = 1'b1;
        @(negedge clk);
        #2;
        chk(cnt == CW'(4), "R5 switch back keeps count", int'(cnt), 4);
        @(negedge clk);

        // R8: flag-clear write on the overflow edge.
        restart(2'd0, 1'b1);
        while (!pend_m) @(negedge clk);
        wr(5'b10010);
        #2;
        chk(rd[0] == 1'b1, "R8 overflow beats clear write", int'(rd[0]), 1);
        @(negedge clk);

        // Mixed traffic checked by the model.
        for (int i = 0; i < 80; i++) begin
            repeat (i % 13 + 1) @(negedge clk);
            if (i % 9 == 4) stop = ~stop;
            if (i % 11 == 6) csel = ~csel;
            wr(5'(i * 7 + 16));
        end
        repeat (600) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule